// File: doc/BRIEF.md
# Six-State Timing and Control Sequencer

This block is the timing and decode heart of a small accumulator CPU. A one-hot ring of six timing states runs continuously. The first three states fetch an instruction and the last three execute it. The ring moves on the falling clock edge. The control word is decoded from the current state and the 4-bit opcode held in the instruction register, so each word is already settled when the datapath registers load on the next rising edge.

Every instruction takes exactly six states. Execute states that an instruction does not use produce the all-zero (inactive) control word. A halt instruction stops the ring and raises a sticky halted flag. Only reset clears the flag. The datapath, the memory and any interrupt handling are outside this block.

Top module: `tstate_sequencer`

## Requirements
- R1: While `rst` is high (asynchronous, active high), `tstate` is 6'b000001 (state one), `ctrl_word` is 12'h000 and `halted` is 0.
- R2: `tstate` always has exactly one bit set, with bit k meaning state k+1. At each falling clock edge it moves from state k to state k+1, and from state six back to state one, unless the halt rule R9 applies.
- R3: The control word bits are: 11 count up the program counter, 10 program counter drives bus, 9 load address register, 8 RAM drives bus, 7 load instruction register, 6 instruction address field drives bus, 5 load accumulator, 4 accumulator drives bus, 3 subtract select, 2 adder result drives bus, 1 load B register, 0 load output register. For every opcode the fetch words are 12'h600 in state one, 12'h800 in state two and 12'h180 in state three.
- R4: Opcode 4'b0000 (load accumulator) gives 12'h240 in state four and 12'h120 in state five.
- R5: Opcode 4'b0001 (add) gives 12'h240 in state four, 12'h102 in state five and 12'h024 in state six.
- R6: Opcode 4'b0010 (subtract) gives 12'h240 in state four, 12'h102 in state five and 12'h02C in state six. Bit 3 is never set for any other opcode or state.
- R7: Opcode 4'b1110 (output) gives 12'h011 in state four.
- R8: Execute states that an instruction leaves unused give 12'h000. Every opcode other than 0000, 0001, 0010, 1110 and 1111 gives 12'h000 in all three execute states.
- R9: With opcode 4'b1111 (halt) in state four, the next falling edge sets `halted` and the ring stays in state four. From then on `ctrl_word` stays 12'h000, `tstate` stays in state four and later opcode changes have no effect until reset.
- R10: Asserting `rst` in the middle of an instruction or while halted immediately returns `tstate` to state one, clears `halted` and forces `ctrl_word` to 12'h000. After release, the first state is state one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; ring moves on falling edge |
| rst | input | 1 | Asynchronous active-high reset |
| opcode | input | 4 | Upper nibble of the instruction register |
| tstate | output | 6 | One-hot timing state, bit 0 = state one |
| ctrl_word | output | 12 | Decoded control word for the next rising edge |
| halted | output | 1 | Sticky halt flag |

## Verification
Both `tstate` and `ctrl_word` change only at a falling edge, or when the opcode changes. Each result is therefore due half a clock after the falling edge that enters its state, and it holds until the next falling edge. The bench changes the opcode just after a falling edge. It samples just after each rising edge, where exactly one state is settled. The driver queues one expected item per state, and the monitor consumes one item per rising edge. The halt flag is due one falling edge after state four is sampled with the halt opcode. The bench then expects repeated frozen items. Asynchronous reset is checked one time unit after it is raised, without waiting for any clock.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int NUM_T   = 6;
    localparam int FETCH_T = 3;
    localparam int EXEC_T  = NUM_T - FETCH_T;
    localparam int OP_W    = 4;
    localparam int CW_W    = 12;

    localparam logic [OP_W-1:0] OP_LDA = 4'b0000;
    localparam logic [OP_W-1:0] OP_ADD = 4'b0001;
    localparam logic [OP_W-1:0] OP_SUB = 4'b0010;
    localparam logic [OP_W-1:0] OP_OUT = 4'b1110;
    localparam logic [OP_W-1:0] OP_HLT = 4'b1111;

    localparam int B_PC_INC  = 11;
    localparam int B_PC_DRV  = 10;
    localparam int B_AR_LD   = 9;
    localparam int B_RAM_DRV = 8;
    localparam int B_IR_LD   = 7;
    localparam int B_IR_DRV  = 6;
    localparam int B_ACC_LD  = 5;
    localparam int B_ACC_DRV = 4;
    localparam int B_SUB     = 3;
    localparam int B_ALU_DRV = 2;
    localparam int B_B_LD    = 1;
    localparam int B_OUT_LD  = 0;

    localparam logic [CW_W-1:0] CW_IDLE = '0;

    typedef struct packed {
        logic [NUM_T-1:0] ring;
        logic             stop;
    } ring_state_t;

    function automatic logic [CW_W-1:0] cw_bit(input int pos);
        logic [CW_W-1:0] w;
        w = '0;
        w[pos] = 1'b1;
        return w;
    endfunction

    function automatic logic [CW_W-1:0] fetch_word(input int slot);
        case (slot)
            0:       return cw_bit(B_PC_DRV) | cw_bit(B_AR_LD);
            1:       return cw_bit(B_PC_INC);
            2:       return cw_bit(B_RAM_DRV) | cw_bit(B_IR_LD);
            default: return CW_IDLE;
        endcase
    endfunction

    function automatic logic [CW_W-1:0] exec_word(input logic [OP_W-1:0] op,
                                                  input int slot);
        logic is_math;
        is_math = (op == OP_ADD) || (op == OP_SUB);
        case (slot)
            0: begin
                if (op == OP_LDA || is_math)
                    return cw_bit(B_IR_DRV) | cw_bit(B_AR_LD);
                else if (op == OP_OUT)
                    return cw_bit(B_ACC_DRV) | cw_bit(B_OUT_LD);
                else
                    return CW_IDLE;
            end
            1: begin
                if (op == OP_LDA)
                    return cw_bit(B_RAM_DRV) | cw_bit(B_ACC_LD);
                else if (is_math)
                    return cw_bit(B_RAM_DRV) | cw_bit(B_B_LD);
                else
                    return CW_IDLE;
            end
            2: begin
                if (op == OP_ADD)
                    return cw_bit(B_ALU_DRV) | cw_bit(B_ACC_LD);
                else if (op == OP_SUB)
                    return cw_bit(B_ALU_DRV) | cw_bit(B_ACC_LD) | cw_bit(B_SUB);
                else
                    return CW_IDLE;
            end
            default: return CW_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/seq_ring.sv
module seq_ring
    import seq_pkg::*;
#(
    parameter int N_T     = NUM_T,
    parameter int N_FETCH = FETCH_T,
    parameter int W_OP    = OP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W_OP-1:0]  opcode,
    output logic [N_T-1:0]   tstate,
    output logic             halted
);

    localparam logic [N_T-1:0] RING_INIT = {{(N_T-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [N_T-1:0] ring;
        logic           stop;
    } rs_t;

    rs_t st_d, st_q;
    logic hlt_hit_d;

    always_comb begin
        st_d      = st_q;
        hlt_hit_d = st_q.ring[N_FETCH] && (opcode == OP_HLT);
        if (!st_q.stop) begin
            if (hlt_hit_d) begin
                st_d.stop = 1'b1;
            end else begin
                st_d.ring = {st_q.ring[N_T-2:0], st_q.ring[N_T-1]};
            end
        end
    end

    always_ff @(negedge clk or posedge rst) begin
        if (rst) begin
            st_q.ring <= RING_INIT;
            st_q.stop <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tstate = st_q.ring;
    assign halted = st_q.stop;

endmodule

// File: rtl/seq_fetch_dec.sv
module seq_fetch_dec
    import seq_pkg::*;
#(
    parameter int N_T     = NUM_T,
    parameter int N_FETCH = FETCH_T,
    parameter int W_CW    = CW_W
) (
    input  logic [N_FETCH-1:0] fetch_ring,
    output logic [W_CW-1:0]    fetch_cw
);

    logic [W_CW-1:0] slot_w [N_FETCH];

    for (genvar j = 0; j < N_FETCH; j++) begin : g_fslot
        assign slot_w[j] = fetch_ring[j] ? fetch_word(j) : '0;
    end

    always_comb begin
        fetch_cw = '0;
        for (int j = 0; j < N_FETCH; j++) begin
            fetch_cw = fetch_cw | slot_w[j];
        end
    end

endmodule

// File: rtl/seq_exec_dec.sv
module seq_exec_dec
    import seq_pkg::*;
#(
    parameter int N_EXEC = EXEC_T,
    parameter int W_OP   = OP_W,
    parameter int W_CW   = CW_W
) (
    input  logic [N_EXEC-1:0] exec_ring,
    input  logic [W_OP-1:0]   opcode,
    output logic [W_CW-1:0]   exec_cw
);

    logic [W_CW-1:0] slot_w [N_EXEC];

    for (genvar j = 0; j < N_EXEC; j++) begin : g_xslot
        assign slot_w[j] = exec_ring[j] ? exec_word(opcode, j) : '0;
    end

    always_comb begin
        exec_cw = '0;
        for (int j = 0; j < N_EXEC; j++) begin
            exec_cw = exec_cw | slot_w[j];
        end
    end

endmodule

// File: rtl/tstate_sequencer.sv
module tstate_sequencer
    import seq_pkg::*;
#(
    parameter int N_T     = NUM_T,
    parameter int N_FETCH = FETCH_T,
    parameter int W_OP    = OP_W,
    parameter int W_CW    = CW_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W_OP-1:0]  opcode,
    output logic [N_T-1:0]   tstate,
    output logic [W_CW-1:0]  ctrl_word,
    output logic             halted
);

    localparam int N_EXEC = N_T - N_FETCH;

    logic [W_CW-1:0] fetch_cw;
    logic [W_CW-1:0] exec_cw;

    seq_ring #(
        .N_T    (N_T),
        .N_FETCH(N_FETCH),
        .W_OP   (W_OP)
    ) u_ring (
        .clk   (clk),
        .rst   (rst),
        .opcode(opcode),
        .tstate(tstate),
        .halted(halted)
    );

    seq_fetch_dec #(
        .N_T    (N_T),
        .N_FETCH(N_FETCH),
        .W_CW   (W_CW)
    ) u_fetch (
        .fetch_ring(tstate[N_FETCH-1:0]),
        .fetch_cw  (fetch_cw)
    );

    seq_exec_dec #(
        .N_EXEC(N_EXEC),
        .W_OP  (W_OP),
        .W_CW  (W_CW)
    ) u_exec (
        .exec_ring(tstate[N_T-1:N_FETCH]),
        .opcode   (opcode),
        .exec_cw  (exec_cw)
    );

    always_comb begin
        if (rst || halted) begin
            ctrl_word = '0;
        end else begin
            ctrl_word = fetch_cw | exec_cw;
        end
    end

endmodule

// File: rtl/tstate_sequencer_chk.sv
module tstate_sequencer_chk
    import seq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [OP_W-1:0]   opcode,
    input logic [NUM_T-1:0]  tstate,
    input logic [CW_W-1:0]   ctrl_word,
    input logic              halted
);

    assert_reset_R1: assert property (@(posedge clk)
        rst |-> (tstate == 6'b000001 && ctrl_word == 12'h000 && !halted));

    assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(tstate) == 1);

    assert_rotate_R2: assert property (@(negedge clk) disable iff (rst)
        (!halted && !(tstate[FETCH_T] && opcode == OP_HLT))
        |=> (tstate == {$past(tstate[NUM_T-2:0]), $past(tstate[NUM_T-1])}));

    assert_fetch1_R3: assert property (@(posedge clk) disable iff (rst)
        tstate[0] |-> ctrl_word == 12'h600);

    assert_fetch2_R3: assert property (@(posedge clk) disable iff (rst)
        tstate[1] |-> ctrl_word == 12'h800);

    assert_fetch3_R3: assert property (@(posedge clk) disable iff (rst)
        tstate[2] |-> ctrl_word == 12'h180);

    assert_sub_bit_R6: assert property (@(posedge clk) disable iff (rst)
        ctrl_word[B_SUB] |-> (opcode == OP_SUB && tstate[NUM_T-1]));

    assert_out_tail_nop_R8: assert property (@(posedge clk) disable iff (rst)
        ((tstate[4] || tstate[5]) && opcode == OP_OUT) |-> ctrl_word == 12'h000);

    assert_halt_sticky_R9: assert property (@(negedge clk) disable iff (rst)
        halted |=> (halted && $stable(tstate)));

    assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        halted |-> (ctrl_word == 12'h000 && tstate[FETCH_T]));

endmodule

bind tstate_sequencer tstate_sequencer_chk u_chk (.*);

// File: tb/sim_tstate_sequencer.sv
module sim_tstate_sequencer;

    typedef struct {
        logic [5:0]  ts;
        logic [11:0] cw;
        logic        h;
        string       tag;
    } exp_t;

    logic        clk;
    logic        rst;
    logic [3:0]  opcode;
    logic [5:0]  tstate;
    logic [11:0] ctrl_word;
    logic        halted;

    int checks   = 0;
    int failures = 0;
    exp_t sb_q[$];

    tstate_sequencer u0 (
        .clk      (clk),
        .rst      (rst),
        .opcode   (opcode),
        .tstate   (tstate),
        .ctrl_word(ctrl_word),
        .halted   (halted)
    );

    initial begin
        clk = 1'b0;
        forever #10 clk = ~clk;
    end

    function automatic logic [11:0] model_cw(input logic [3:0] op, input int t);
        case (t)
            1: return 12'h600;
            2: return 12'h800;
            3: return 12'h180;
            4: begin
                if (op == 4'b0000 || op == 4'b0001 || op == 4'b0010) return 12'h240;
                if (op == 4'b1110) return 12'h011;
                return 12'h000;
            end
            5: begin
                if (op == 4'b0000) return 12'h120;
                if (op == 4'b0001 || op == 4'b0010) return 12'h102;
                return 12'h000;
            end
            6: begin
                if (op == 4'b0001) return 12'h024;
                if (op == 4'b0010) return 12'h02C;
                return 12'h000;
            end
            default: return 12'h000;
        endcase
    endfunction

    function automatic string pick_tag(input logic [3:0] op, input int t, input logic [11:0] cw);
        if (t <= 3) return "R3";
        if (op == 4'b1111) return "R9";
        if (cw == 12'h000) return "R8";
        case (op)
            4'b0000: return "R4";
            4'b0001: return "R5";
            4'b0010: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic [5:0] ts, input logic [11:0] cw,
                        input logic h, input string tag);
        exp_t e;
        e.ts = ts; e.cw = cw; e.h = h; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Driver: called just after the falling edge that enters state one.
    task automatic run_instr(input logic [3:0] op);
        opcode = op;
        for (int t = 1; t <= 6; t++) begin
            logic [11:0] w;
            w = model_cw(op, t);
            push(6'b000001 << (t - 1), w, 1'b0, pick_tag(op, t, w));
        end
        repeat (6) @(negedge clk);
        #1;
    endtask

    task automatic run_halt();
        opcode = 4'b1111;
        for (int t = 1; t <= 4; t++) begin
            logic [11:0] w;
            w = model_cw(4'b1111, t);
            push(6'b000001 << (t - 1), w, 1'b0, pick_tag(4'b1111, t, w));
        end
        for (int k = 0; k < 5; k++) push(6'b001000, 12'h000, 1'b1, "R9");
        repeat (4) @(negedge clk);
        #1;
        opcode = 4'b0001;   // must be ignored once halted (R9)
        repeat (5) @(negedge clk);
        #1;
    endtask

    // Monitor: one expected item per rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check("R2", "tstate", 32'(tstate), 32'(e.ts));
                check(e.tag, "ctrl_word", 32'(ctrl_word), 32'(e.cw));
                check(e.tag, "halted", 32'(halted), 32'(e.h));
            end
        end
    end

    initial begin
        #400000;
        failures++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b0;
        opcode = 4'b0000;
        #1 rst = 1'b1;
        @(posedge clk);
        #2;
        check("R1", "reset tstate", 32'(tstate), 32'h1);
        check("R1", "reset ctrl_word", 32'(ctrl_word), 32'h0);
        check("R1", "reset halted", 32'(halted), 32'h0);
        @(negedge clk);
        #1 rst = 1'b0;

        run_instr(4'b0000);   // R4
        run_instr(4'b0001);   // R5
        run_instr(4'b0010);   // R6
        run_instr(4'b1110);   // R7
        run_instr(4'b0101);   // R8 unknown opcode
        run_instr(4'b1010);   // R8 unknown opcode
        run_instr(4'b0001);   // R5 back-to-back wrap (R2)

        // R10: reset mid-instruction while in state three
        opcode = 4'b0010;
        @(negedge clk);
        @(negedge clk);
        #1;
        check("R10", "pre-reset tstate", 32'(tstate), 32'h4);
        rst = 1'b1;
        #1;
        check("R10", "mid reset tstate", 32'(tstate), 32'h1);
        check("R10", "mid reset ctrl_word", 32'(ctrl_word), 32'h0);
        @(negedge clk);
        #1 rst = 1'b0;

        run_instr(4'b0010);   // R6 after reset
        run_halt();           // R9

        // R10: reset clears a halt
        rst = 1'b1;
        #1;
        check("R10", "halt reset halted", 32'(halted), 32'h0);
        check("R10", "halt reset tstate", 32'(tstate), 32'h1);
        check("R10", "halt reset ctrl_word", 32'(ctrl_word), 32'h0);
        @(negedge clk);
        #1 rst = 1'b0;

        run_instr(4'b0000);   // R4 resumes after halt

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule